// File: doc/BRIEF.md
# Contact Card Session Sequencer

This block is the card-side controller of a contact smart card emulator. It watches three terminal-driven signals: supply present, card clock and an active-low card reset. It steps through a power-up sequence gated by these signals. Once the terminal releases reset, the block waits a programmed number of card clock cycles. It then hands a fixed Answer-To-Reset (ATR) byte string, one byte at a time, to a character transmitter over a valid/ready byte interface. After the ATR it waits for command header bytes from a receiver.

The card clock is resampled in the system clock domain. Its rising edges drive three things: a presence detector, the pre-ATR delay and a bit-rate strobe. The strobe fires once per elementary time unit (ETU), which is 372 card clock cycles. The strobe counter restarts when the ATR begins, so the transmitter starts its first character on a fresh ETU boundary. If the supply drops, the sequence returns to its start from any state. If the card clock stops, or if reset is asserted again, the sequence falls back to the matching earlier wait state.

Top module: `card_session_seq`

## Requirements
- R1: After system reset, `seq_state` is 0 (waiting for supply), `tx_valid` is 0 and `etu_tick` is 0. The state codes are: 0 wait supply, 1 wait clock, 2 wait reset release, 3 pre-ATR delay, 4 sending ATR, 5 wait header, 6 in header.
- R2: With `vcc_in` high in state 0, the state becomes 1 no later than three system clocks later. While `vcc_in` is low, the state stays 0.
- R3: If the synchronised supply is low in any state other than 0, the next state is 0. The block reaches state 0 within four system clocks of `vcc_in` falling, and `tx_valid` is then 0.
- R4: The state leaves 1 for 2 only after 16 card clock rising edges have been seen within one 4096-cycle system clock window. A card clock whose edges are 300 system clocks apart never qualifies.
- R5: If no card clock rising edge is seen for 4096 system clocks in states 2 to 6, the state returns to 1.
- R6: In state 2 the block waits while `crst_n_in` is low. Once the synchronised reset input is high (released), the state becomes 3.
- R7: State 3 lasts for ATR_DELAY (default 400) card clock rising edges, then the state becomes 4.
- R8: In state 4, `tx_valid` is high and `tx_data` presents the bytes 3B, 80, 80, 81, 1F, C7, 59 in that order. The block moves to the next byte on each cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_data` holds its value.
- R9: When the seventh byte is accepted, the state becomes 5 and `tx_valid` falls.
- R10: In states 4 to 6, `etu_tick` pulses once every 372 card clock rising edges, counted from entry into state 4. It never pulses in any other state.
- R11: If the card reset input goes low in states 3 to 6, the state returns to 2.
- R12: In state 5, an `rx_valid` pulse moves the state to 6. After five `rx_valid` pulses in total, counting the one that entered state 6, the state returns to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| vcc_in | input | 1 | Supply-present input from the terminal, asynchronous |
| cclk_in | input | 1 | Card clock from the terminal, asynchronous, slower than clk/2 |
| crst_n_in | input | 1 | Card reset from the terminal, active low, asynchronous |
| tx_valid | output | 1 | ATR byte available for the transmitter |
| tx_data | output | 8 | Current ATR byte |
| tx_ready | input | 1 | Transmitter accepts the current byte |
| etu_tick | output | 1 | One-cycle strobe per elementary time unit |
| rx_valid | input | 1 | Receiver delivers one header byte |
| seq_state | output | 3 | Current sequencer state code |

## Verification
The assertions check the transition rules that hold on every cycle. These are: the forced return to state 0 on supply loss, the fall-back to state 2 on reset reassertion, entry into the header state, the causes behind each step from state 1 to 2, from 2 to 3 and from 4 to 5, and the holding of `tx_data` under backpressure. Some behaviour shows up only over long stretches of time, so only the bench scenarios can cover it. This includes the ETU period, the length of the pre-ATR delay, the rejection of a card clock that is too slow, the loss-of-clock timeout and the complete ATR byte order.

// File: rtl/card_session_seq.sv
module card_session_seq #(
  parameter int ATR_LEN = 7,
  parameter logic [8*ATR_LEN-1:0] ATR_BYTES = 56'h3B_80_80_81_1F_C7_59,
  parameter int ATR_DELAY = 400,
  parameter int ETU_CLKS = 372,
  parameter int CLK_EDGES = 16,
  parameter int CLK_WINDOW = 4096,
  parameter int HDR_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_in,
  input  logic       cclk_in,
  input  logic       crst_n_in,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       etu_tick,
  input  logic       rx_valid,
  output logic [2:0] seq_state
);
  localparam int IW = $clog2(ATR_LEN + 1);
  localparam int DW = $clog2(ATR_DELAY + 1);
  localparam int EW = $clog2(ETU_CLKS + 1);
  localparam int CW = $clog2(CLK_EDGES + 1);
  localparam int WW = $clog2(CLK_WINDOW + 1);
  localparam int HW = $clog2(HDR_LEN + 1);

  typedef enum logic [2:0] {
    S_OFF = 3'd0, S_CLK = 3'd1, S_RST = 3'd2, S_DLY = 3'd3,
    S_ATR = 3'd4, S_HDR_WAIT = 3'd5, S_HDR_IN = 3'd6
  } seq_t;

  seq_t          state;
  logic [1:0]    vcc_sy, crst_sy;
  logic [2:0]    cclk_sy;
  logic          vcc_s, crst_s, cedge, clk_ok, etu_run;
  logic [WW-1:0] win_cnt, idle_cnt;
  logic [CW-1:0] edge_cnt;
  logic [DW-1:0] dly_cnt;
  logic [IW-1:0] atr_idx;
  logic [HW-1:0] hdr_cnt;
  logic [EW-1:0] etu_cnt;

  assign vcc_s  = vcc_sy[1];
  assign crst_s = crst_sy[1];
  assign cedge  = cclk_sy[1] & ~cclk_sy[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_sy  <= '0;
      crst_sy <= '0;
      cclk_sy <= '0;
    end else begin
      vcc_sy  <= {vcc_sy[0], vcc_in};
      crst_sy <= {crst_sy[0], crst_n_in};
      cclk_sy <= {cclk_sy[1:0], cclk_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      idle_cnt <= '0;
      edge_cnt <= '0;
      clk_ok   <= 1'b0;
    end else begin
      win_cnt <= (win_cnt == WW'(CLK_WINDOW - 1)) ? '0 : win_cnt + 1'b1;
      if (cedge)
        idle_cnt <= '0;
      else if (idle_cnt != WW'(CLK_WINDOW - 1))
        idle_cnt <= idle_cnt + 1'b1;
      if (!cedge && idle_cnt == WW'(CLK_WINDOW - 1)) begin
        clk_ok   <= 1'b0;
        edge_cnt <= '0;
      end else if (win_cnt == WW'(CLK_WINDOW - 1)) begin
        edge_cnt <= CW'(cedge);
      end else if (cedge && !clk_ok) begin
        if (edge_cnt == CW'(CLK_EDGES - 1))
          clk_ok <= 1'b1;
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
    end else if (!vcc_s) begin
      state <= S_OFF;
    end else if (state >= S_RST && !clk_ok) begin
      state <= S_CLK;
    end else if (state >= S_DLY && !crst_s) begin
      state <= S_RST;
    end else begin
      case (state)
        S_OFF:      state <= S_CLK;
        S_CLK:      if (clk_ok) state <= S_RST;
        S_RST:      if (crst_s) state <= S_DLY;
        S_DLY:      if (cedge && dly_cnt == DW'(ATR_DELAY - 1)) state <= S_ATR;
        S_ATR:      if (tx_ready && atr_idx == IW'(ATR_LEN - 1)) state <= S_HDR_WAIT;
        S_HDR_WAIT: if (rx_valid) state <= S_HDR_IN;
        S_HDR_IN:   if (rx_valid && hdr_cnt == HW'(HDR_LEN - 1)) state <= S_HDR_WAIT;
        default:    state <= S_OFF;
      endcase
    end
  end

  assign etu_run = (state == S_ATR) || (state == S_HDR_WAIT) || (state == S_HDR_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_cnt <= '0;
      atr_idx <= '0;
      hdr_cnt <= '0;
      etu_cnt <= '0;
    end else begin
      dly_cnt <= (state == S_DLY) ? dly_cnt + DW'(cedge) : '0;
      atr_idx <= (state == S_ATR) ? atr_idx + IW'(tx_ready) : '0;
      if (state == S_HDR_IN)
        hdr_cnt <= hdr_cnt + HW'(rx_valid);
      else
        hdr_cnt <= (state == S_HDR_WAIT && rx_valid) ? HW'(1) : '0;
      if (!etu_run)
        etu_cnt <= '0;
      else if (cedge)
        etu_cnt <= (etu_cnt == EW'(ETU_CLKS - 1)) ? '0 : etu_cnt + 1'b1;
    end
  end

  assign etu_tick  = etu_run && cedge && (etu_cnt == EW'(ETU_CLKS - 1));
  assign tx_valid  = (state == S_ATR);
  assign tx_data   = tx_valid ? ATR_BYTES[8*(ATR_LEN - 1 - int'(atr_idx)) +: 8] : 8'h00;
  assign seq_state = state;
endmodule

// File: rtl/card_session_seq_chk.sv
module card_session_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_s,
  input logic       crst_s,
  input logic       clk_ok,
  input logic [2:0] state,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rx_valid
);
  assert_supply_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_s && state != 3'd0) |=> state == 3'd0);

  assert_clock_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && $past(state) == 3'd1) |-> $past(clk_ok));

  assert_reset_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && $past(state) == 3'd2) |-> $past(crst_s));

  assert_hold_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && vcc_s && clk_ok && crst_s) |=> (tx_valid && $stable(tx_data)));

  assert_atr_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5 && $past(state) == 3'd4) |-> $past(tx_ready));

  assert_rereset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_s && clk_ok && !crst_s && state >= 3'd3 && state <= 3'd6) |=> state == 3'd2);

  assert_header_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_s && clk_ok && crst_s && state == 3'd5 && rx_valid) |=> state == 3'd6);
endmodule

bind card_session_seq card_session_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .vcc_s(vcc_s), .crst_s(crst_s), .clk_ok(clk_ok),
  .state(state), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid)
);

// File: tb/card_session_seq_test.sv
`timescale 1ns/1ps
module card_session_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vcc_in = 1'b0;
  logic       cclk_in = 1'b0;
  logic       crst_n_in = 1'b0;
  logic       tx_ready = 1'b0;
  logic       rx_valid = 1'b0;
  logic       tx_valid, etu_tick;
  logic [7:0] tx_data;
  logic [2:0] seq_state;

  int  nchk = 0, nbad = 0, stray = 0;
  int  cclk_half = 20;
  bit  cclk_on = 1'b0;
  bit  done = 1'b0;

  localparam bit [11:0] ATR_VEC [0:6] = '{12'h23B, 12'h080, 12'h380, 12'h081,
                                          12'h01F, 12'h1C7, 12'h059};

  card_session_seq uut (
    .clk(clk), .rst_n(rst_n), .vcc_in(vcc_in), .cclk_in(cclk_in),
    .crst_n_in(crst_n_in), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .etu_tick(etu_tick), .rx_valid(rx_valid),
    .seq_state(seq_state)
  );

  always #5 clk = ~clk;

  always begin
    if (cclk_on) begin
      #(cclk_half) cclk_in = ~cclk_in;
    end else begin
      cclk_in = 1'b0;
      #10;
    end
  end

  always @(negedge clk)
    if (rst_n && etu_tick && !(seq_state inside {3'd4, 3'd5, 3'd6})) stray++;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input logic [2:0] s, input int lim, output int n);
    n = 0;
    while (seq_state != s && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_tick(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!etu_tick && n < lim);
  endtask

  task automatic pulse_rx;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int n, t1;
    cycles(3);
    check("R1 state", seq_state, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 etu_tick", etu_tick, 0);
    rst_n = 1'b1;
    cycles(20);
    check("R2 no supply", seq_state, 0);
    vcc_in = 1'b1;
    cycles(4);
    check("R2 supply seen", seq_state, 1);

    cclk_half = 1500;
    cclk_on = 1'b1;
    cycles(9000);
    check("R4 slow clock rejected", seq_state, 1);
    cclk_on = 1'b0;
    cycles(10);
    cclk_half = 20;
    cclk_on = 1'b1;
    cycles(300);
    check("R4 clock accepted", seq_state, 2);

    cycles(200);
    check("R6 held in reset", seq_state, 2);
    crst_n_in = 1'b1;
    wait_state(3'd3, 20, n);
    check_range("R6 release", n, 1, 4);
    wait_state(3'd4, 3000, n);
    check_range("R7 delay cycles", n, 1590, 1615);
    check("R8 valid at entry", tx_valid, 1);

    wait_tick(3000, t1);
    check_range("R10 first etu", t1, 1480, 1496);
    wait_tick(3000, n);
    check("R10 etu period", n, 1488);

    foreach (ATR_VEC[i]) begin
      for (int k = 0; k < int'(ATR_VEC[i][11:8]); k++) begin
        tx_ready = 1'b0;
        check("R8 held byte", {tx_valid, tx_data}, {1'b1, ATR_VEC[i][7:0]});
        @(negedge clk);
      end
      tx_ready = 1'b1;
      check("R8 byte order", {tx_valid, tx_data}, {1'b1, ATR_VEC[i][7:0]});
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check("R9 header wait", seq_state, 5);
    check("R9 valid low", tx_valid, 0);

    pulse_rx();
    check("R12 header start", seq_state, 6);
    for (int k = 0; k < 3; k++) pulse_rx();
    check("R12 header partial", seq_state, 6);
    pulse_rx();
    check("R12 header done", seq_state, 5);

    crst_n_in = 1'b0;
    cycles(4);
    check("R11 reset in header wait", seq_state, 2);
    crst_n_in = 1'b1;
    wait_state(3'd4, 3000, n);
    check("R11 reached ATR again", seq_state, 4);
    crst_n_in = 1'b0;
    cycles(4);
    check("R11 reset during ATR", seq_state, 2);
    check("R11 valid dropped", tx_valid, 0);

    cclk_on = 1'b0;
    cycles(4300);
    check("R5 clock lost", seq_state, 1);

    cclk_on = 1'b1;
    cycles(300);
    check("R4 clock regained", seq_state, 2);
    crst_n_in = 1'b1;
    wait_state(3'd3, 20, n);
    check("R6 delay again", seq_state, 3);
    vcc_in = 1'b0;
    cycles(4);
    check("R3 supply loss", seq_state, 0);
    check("R3 valid low", tx_valid, 0);
    check("R10 stray ticks", stray, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule